// File: doc/BRIEF.md
# Continuation-Stack Fibonacci Engine

This block computes the Fibonacci number F(n), with F(1) = F(2) = 1, by running the doubly recursive definition without a hardware call stack. Each pending addition is saved as a continuation record in a small on-chip memory, and the engine advances one step per clock. A step either handles a call record (argument n, continuation pointer k) or a return record (a loaded continuation plus a carried value). A call with n of 1 or 2 turns into a return of 1 to the record at k. Any larger n saves an "after first half" record (n, k) and calls n-1. Returning to that record saves an "after second half" record (partial sum, k) and calls n-2. Returning to the second record loads its parent and returns the sum. Returning to the final record ends the run.

Records go into the memory through a bump pointer that is rewound at every accepted start. Nothing is ever freed. A run for n therefore needs 2·F(n)−1 records. If the memory fills, the run ends with an error flag. The user pulses `start` with `n_in` while the engine is idle, then waits for the one-cycle `done` pulse and reads `result`.

Top module: `fib_cont_engine`

## Requirements
- R1: After reset, `busy`, `done`, `err` and `result` are all 0.
- R2: For an accepted start with 1 ≤ n whose run fits in memory, `done` pulses and `result` equals F(n) mod 2^VAL_W, with F(1) = F(2) = 1.
- R3: `done` lasts exactly one cycle. `busy` is 1 from the cycle after an accepted nonzero start until the cycle in which `done` rises, and 0 in that cycle. `result` keeps its value until the next `done`.
- R4: A start with n = 0 is answered in the next cycle with `done` = 1, `result` = 0 and `err` = 0, and no run is started.
- R5: A `start` pulse while `busy` is 1 is ignored. The running job finishes with the result for its own n.
- R6: A run for n stores 2·F(n)−1 records, one per memory entry. If that exceeds DEPTH (1024 by default, so n ≥ 15), the run ends with `done` = 1, `err` = 1 and `result` = 0.
- R7: `err` stays 1 after an overflow until the next accepted start, which clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Start strobe, taken only while idle |
| n_in | input | VAL_W | Fibonacci index, sampled with `start` |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | VAL_W | F(n) of the last run, 0 after n = 0 or an error |
| err | output | 1 | Last run ran out of record memory |

## Verification
The assertions watch the following on every cycle:
- `done` is a single-cycle pulse issued only while returning to idle.
- The bump pointer advances by exactly one for each stored record and never passes the memory size.
- No call step ever holds a zero argument.
- `err` holds until a new start is accepted.
- An n = 0 start is answered in the following cycle.

Only the bench's scenarios show the following:
- The numeric results match an iterative Fibonacci computed on the bench.
- The boundary falls between n = 14, which fits, and n = 15, which overflows.
- A start pulse during a run leaves that run's result untouched.

// File: rtl/fibk_pkg.sv
package fibk_pkg;

  // Continuation kinds; the core decodes this tag when a record is returned to.
  typedef enum logic [1:0] {
    KIND_FINAL  = 2'd0,  // end of the whole computation
    KIND_AFTER1 = 2'd1,  // holds n, pointer; first half still pending
    KIND_AFTER2 = 2'd2   // holds first half sum, pointer
  } kind_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CALL = 2'd1,
    ST_RET  = 2'd2
  } state_e;

  // A call whose argument is 1 or 2 returns 1 without storing a record.
  function automatic logic is_base_arg(input logic [31:0] n);
    return (n == 32'd1) || (n == 32'd2);
  endfunction

endpackage

// File: rtl/fibk_cont_mem.sv
module fibk_cont_mem #(
  parameter int WIDTH = 28,
  parameter int DEPTH = 1024,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    a,
  input  logic [WIDTH-1:0] di,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] cells_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells_q[a] <= di;
  end

  // Combinational read: a loaded record is usable in the same step.
  assign dout = cells_q[a];

endmodule

// File: rtl/fibk_bump_alloc.sv
module fibk_bump_alloc #(
  parameter int DEPTH = 1024,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          take,
  output logic [AW-1:0] addr,
  output logic          full
);

  logic [CW-1:0] used_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      used_q <= '0;
    end else if (clear) begin
      used_q <= take ? CW'(1) : '0;
    end else if (take) begin
      used_q <= used_q + 1'b1;
    end
  end

  assign addr = clear ? '0 : used_q[AW-1:0];
  assign full = (used_q == CW'(DEPTH));

  // R6: nothing is stored once the memory is full
  a_r6_no_take_full: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !clear) |-> !full);

  // R6: one entry per stored record
  a_r6_bump_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !clear) |=> (used_q == $past(used_q) + 1'b1));

  // R6: the pointer never goes past the memory size
  a_r6_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    used_q <= CW'(DEPTH));

endmodule

// File: rtl/fibk_step_core.sv
module fibk_step_core
  import fibk_pkg::*;
#(
  parameter int VAL_W = 16,
  parameter int AW    = 10,
  localparam int REC_W = 2 + VAL_W + AW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [VAL_W-1:0] n_in,
  output logic             busy,
  output logic             done,
  output logic [VAL_W-1:0] result,
  output logic             err,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [REC_W-1:0] mem_wdata,
  input  logic [REC_W-1:0] mem_rdata,
  output logic             alloc_clear,
  output logic             alloc_take,
  input  logic [AW-1:0]    alloc_addr,
  input  logic             alloc_full
);

  typedef struct packed {
    kind_e            kind;
    logic [VAL_W-1:0] val;
    logic [AW-1:0]    ptr;
  } rec_t;

  function automatic logic [REC_W-1:0] pack_rec(input kind_e k,
                                                input logic [VAL_W-1:0] v,
                                                input logic [AW-1:0] p);
    rec_t r;
    r.kind = k;
    r.val  = v;
    r.ptr  = p;
    return r;
  endfunction

  function automatic logic [VAL_W-1:0] wrap_add(input logic [VAL_W-1:0] x,
                                                input logic [VAL_W-1:0] y);
    return x + y;
  endfunction

  function automatic logic [VAL_W-1:0] dec_by(input logic [VAL_W-1:0] x,
                                              input logic [VAL_W-1:0] d);
    return x - d;
  endfunction

  state_e           state_q;
  logic [VAL_W-1:0] cn_q;      // call argument
  logic [AW-1:0]    ck_q;      // call continuation pointer
  rec_t             rrec_q;    // continuation being returned to
  logic [VAL_W-1:0] acc_q;     // value carried by the return
  logic             done_q;
  logic [VAL_W-1:0] res_q;
  logic             err_q;

  rec_t mem_rec;
  assign mem_rec = rec_t'(mem_rdata);

  // Named step events
  logic ev_accept, ev_zero, ev_base, ev_push1, ev_push2, ev_pop2, ev_finish, ev_ovf;
  logic want_store;

  always_comb begin
    ev_accept = (state_q == ST_IDLE) && start && (n_in != '0);
    ev_zero   = (state_q == ST_IDLE) && start && (n_in == '0);
    ev_base   = (state_q == ST_CALL) && is_base_arg(32'(cn_q));
    ev_push1  = (state_q == ST_CALL) && !is_base_arg(32'(cn_q));
    ev_push2  = (state_q == ST_RET) && (rrec_q.kind == KIND_AFTER1);
    ev_pop2   = (state_q == ST_RET) && (rrec_q.kind == KIND_AFTER2);
    ev_finish = (state_q == ST_RET) && (rrec_q.kind != KIND_AFTER1)
                                    && (rrec_q.kind != KIND_AFTER2);
    want_store = ev_push1 || ev_push2;
    ev_ovf    = want_store && alloc_full;
  end

  assign alloc_clear = ev_accept;
  assign alloc_take  = ev_accept || (want_store && !alloc_full);

  always_comb begin
    mem_we    = alloc_take;
    mem_wdata = pack_rec(KIND_FINAL, '0, '0);
    if (ev_push1)      mem_wdata = pack_rec(KIND_AFTER1, cn_q, ck_q);
    else if (ev_push2) mem_wdata = pack_rec(KIND_AFTER2, acc_q, rrec_q.ptr);
    if (alloc_take)             mem_addr = alloc_addr;
    else if (state_q == ST_CALL) mem_addr = ck_q;
    else                         mem_addr = rrec_q.ptr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cn_q    <= '0;
      ck_q    <= '0;
      rrec_q  <= '0;
      acc_q   <= '0;
      done_q  <= 1'b0;
      res_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            err_q <= 1'b0;
            if (ev_zero) begin
              res_q  <= '0;
              done_q <= 1'b1;
            end else begin
              cn_q    <= n_in;
              ck_q    <= alloc_addr;
              state_q <= ST_CALL;
            end
          end
        end
        ST_CALL: begin
          if (ev_base) begin
            rrec_q  <= mem_rec;
            acc_q   <= VAL_W'(1);
            state_q <= ST_RET;
          end else if (ev_ovf) begin
            err_q   <= 1'b1;
            res_q   <= '0;
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            cn_q <= dec_by(cn_q, VAL_W'(1));
            ck_q <= alloc_addr;
          end
        end
        ST_RET: begin
          if (ev_push2) begin
            if (ev_ovf) begin
              err_q   <= 1'b1;
              res_q   <= '0;
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              cn_q    <= dec_by(rrec_q.val, VAL_W'(2));
              ck_q    <= alloc_addr;
              state_q <= ST_CALL;
            end
          end else if (ev_pop2) begin
            rrec_q <= mem_rec;
            acc_q  <= wrap_add(rrec_q.val, acc_q);
          end else begin
            res_q   <= acc_q;
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy   = (state_q != ST_IDLE);
  assign done   = done_q;
  assign result = res_q;
  assign err    = err_q;

  // R3: done is a single-cycle pulse
  a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R3: done only appears with the engine back at idle
  a_r3_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy);

  // R4: zero argument answered in the next cycle
  a_r4_zero_next: assert property (@(posedge clk) disable iff (!rst_n)
    ev_zero |=> (done_q && res_q == '0 && !err_q));

  // R2: every call step carries a nonzero argument
  a_r2_call_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CALL) |-> (cn_q != '0));

  // R7: the error flag holds until a start is accepted
  a_r7_err_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !(state_q == ST_IDLE && start)) |=> err_q);

  // R6: an overflow ends with a zero result
  a_r6_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ovf |=> (done_q && err_q && res_q == '0));

  // R5: a start during a run does not reload the argument
  a_r5_busy_ignores: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_push1 && !ev_ovf && start) |=> (cn_q == $past(cn_q) - 1'b1));

endmodule

// File: rtl/fib_cont_engine.sv
module fib_cont_engine #(
  parameter int VAL_W = 16,
  parameter int DEPTH = 1024
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [VAL_W-1:0] n_in,
  output logic             busy,
  output logic             done,
  output logic [VAL_W-1:0] result,
  output logic             err
);

  localparam int AW    = $clog2(DEPTH);
  localparam int REC_W = 2 + VAL_W + AW;

  logic             mem_we;
  logic [AW-1:0]    mem_addr;
  logic [REC_W-1:0] mem_wdata;
  logic [REC_W-1:0] mem_rdata;
  logic             alloc_clear;
  logic             alloc_take;
  logic [AW-1:0]    alloc_addr;
  logic             alloc_full;

  fibk_step_core #(.VAL_W(VAL_W), .AW(AW)) u_core (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .n_in        (n_in),
    .busy        (busy),
    .done        (done),
    .result      (result),
    .err         (err),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .mem_rdata   (mem_rdata),
    .alloc_clear (alloc_clear),
    .alloc_take  (alloc_take),
    .alloc_addr  (alloc_addr),
    .alloc_full  (alloc_full)
  );

  fibk_bump_alloc #(.DEPTH(DEPTH)) u_alloc (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (alloc_clear),
    .take  (alloc_take),
    .addr  (alloc_addr),
    .full  (alloc_full)
  );

  fibk_cont_mem #(.WIDTH(REC_W), .DEPTH(DEPTH)) u_mem (
    .clk  (clk),
    .we   (mem_we),
    .a    (mem_addr),
    .di   (mem_wdata),
    .dout (mem_rdata)
  );

endmodule

// File: tb/sim_fib_cont_engine.sv
module sim_fib_cont_engine;

  localparam int VAL_W = 16;
  localparam int DEPTH = 1024;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [VAL_W-1:0] n_in = '0;
  logic             busy, done, err;
  logic [VAL_W-1:0] result;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;

  always #10 clk = ~clk;  // 50 MHz

  fib_cont_engine #(.VAL_W(VAL_W), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .n_in(n_in),
    .busy(busy), .done(done), .result(result), .err(err)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: act=hung exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  // Reference: loop-computed Fibonacci, kept as a wide integer
  function automatic longint ref_fib(input int n);
    longint a = 1, b = 1, t;
    if (n <= 2) return 1;
    for (int i = 3; i <= n; i++) begin
      t = a + b; a = b; b = t;
    end
    return b;
  endfunction

  function automatic bit ref_fits(input int n);
    return (2 * ref_fib(n) - 1) <= DEPTH;
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // Pulse start, then wait at falling edges for done; returns the latency.
  task automatic launch(input int n, output int lat);
    @(negedge clk);
    start = 1'b1; n_in = VAL_W'(n);
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 20000) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic run_and_check(input int n);
    int lat;
    longint expv;
    bit fits;
    fits = (n == 0) ? 1'b1 : ref_fits(n);
    expv = (n == 0 || !fits) ? 0 : (ref_fib(n) % 65536);
    launch(n, lat);
    check(done == 1'b1, "R2 done seen", done, 1);
    check(busy == 1'b0, "R3 busy low at done", busy, 0);
    check(longint'(result) == expv, fits ? "R2 result" : "R6 overflow result", result, expv);
    check(err == !fits, "R6 err flag", err, !fits);
    @(negedge clk);
    check(done == 1'b0, "R3 done one cycle", done, 0);
    check(longint'(result) == expv, "R3 result held", result, expv);
  endtask

  initial begin
    int lat;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1 reset state
    check(busy == 0, "R1 busy", busy, 0);
    check(done == 0, "R1 done", done, 0);
    check(err == 0, "R1 err", err, 0);
    check(result == 0, "R1 result", result, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R4: n = 0 answered in one cycle
    launch(0, lat);
    check(lat == 1, "R4 latency", lat, 1);
    check(done == 1 && result == 0 && err == 0, "R4 zero answer", result, 0);

    // R2/R6: directed sweep 1..20 (15 and up overflow at DEPTH=1024)
    for (int n = 1; n <= 20; n++) run_and_check(n);

    // R6 boundary pair
    run_and_check(14);
    run_and_check(15);

    // R7: err held after overflow, cleared by next start
    repeat (5) @(negedge clk);
    check(err == 1, "R7 err held", err, 1);
    run_and_check(5);
    check(err == 0, "R7 err cleared", err, 0);

    // R5: start during a run is ignored
    @(negedge clk);
    start = 1'b1; n_in = VAL_W'(10);
    @(negedge clk);
    start = 1'b0;
    repeat (7) @(negedge clk);
    check(busy == 1, "R3 busy during run", busy, 1);
    start = 1'b1; n_in = VAL_W'(3);
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 20000) begin
      @(negedge clk);
      lat++;
    end
    check(longint'(result) == 55, "R5 start while busy ignored", result, 55);

    // Random mix
    for (int i = 0; i < 12; i++) begin
      int n;
      n = int'($urandom_range(16, 0));
      run_and_check(n);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule